// File: doc/BRIEF.md
# Power Domain Sequencer with Bus Idle Handshake

This block switches four independent power islands on and off under software control. A small zero-wait register port exposes, for each island, a power-off request bit, a power-state bit, and a bus-idle request bit. A shared register reports the idle-acknowledge and idle-state signals returned by each island's bus interface unit. Software first parks an island's bus traffic through the idle handshake, then asks for power removal. Coming back up, it restores power and then releases the idle request.

Each island has its own state machine with four states. PD_ON moves to PD_FALL when the off request is set. PD_FALL moves to PD_OFF when its transition counter expires. PD_OFF moves to PD_RISE when the off request is cleared. PD_RISE moves to PD_ON when the counter expires. The switch enable is high in PD_ON and PD_RISE. The state bit reads "off" in PD_OFF and PD_RISE. The counter length is taken when the machine leaves a stable state, so a request that changes mid-transition waits for that transition to end. Island 3 takes its fall and rise lengths from the graphics-group counter registers. The other islands use a fixed length of 24 cycles. The core-group counter registers are stored and read back only.

Top module: `pdc_top`

## Requirements
- R1: After reset, every switch enable is 1, every idle request output is 0, registers 0x08, 0x0c and 0x10 read 0, and the four counter registers read 24.
- R2: Register 0x08 holds the off requests for islands 0..3 at bits 7, 14, 8 and 9. A 1 requests power off and a 0 requests power on. The register reads back as written.
- R3: An island's switch enable falls at the first clock edge after its off request is set. Its state bit then reads 1 once N further edges have passed, where N is the fall length. The state bits sit in register 0x0c at bits 7, 10, 8 and 9 for islands 0..3, and 0 means powered.
- R4: An island's switch enable rises at the first clock edge after its off request is cleared while it is off. Its state bit then reads 0 once N further edges have passed, where N is the rise length.
- R5: Register 0x10 holds the idle requests for islands 0..3 at bits 4, 9, 3 and 2. Each bit drives that island's idle request output from the clock edge of the write, and the output changes on no other edge.
- R6: Register 0x14 shows each island's idle-state input at its idle request bit position and its idle-acknowledge input 16 bits higher, with no register delay.
- R7: The registers at 0x34, 0x38, 0x3c and 0x40 hold the core fall, core rise, graphics fall and graphics rise lengths. Island 3 uses the graphics pair. Islands 0..2 always use 24 cycles, whatever the core pair holds.
- R8: An off-request change made while an island is in transition is held and acted on at the first edge after the transition completes.
- R9: Register bits not assigned to an island read 0 and ignore writes. Writes to 0x0c and 0x14 have no effect. Unmapped addresses read 0, and the read data is 0 when no read is requested.
- R10: A programmed length of 0 behaves like a length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_rdata | output | 32 | Read data |
| pd_pwr_en | output | 4 | Power switch enable per island |
| pd_idle_req | output | 4 | Idle request to each island's bus interface unit |
| pd_idle_ack | input | 4 | Idle acknowledge from each bus interface unit |
| pd_idle_st | input | 4 | Idle state from each bus interface unit |

## Verification
The bench runs the full idle-handshake and power sequence on every island. It samples the switch enable and the state bit on the exact cycles around each edge. An off-by-one in the counter would show up as the state bit changing one cycle early or late. A wrong bit map would show up as an acknowledge or state seen in the wrong island's slot. The bench retracts a request in the middle of a fall. A design that aborted the transition would restore the switch before the state bit reached off. It also checks that the core-group lengths leave islands 0..2 at 24 cycles, and that a zero length does not wrap into a very long transition.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int NDOM      = 4;
    localparam int ACK_SHIFT = 16;

    localparam logic [7:0] A_PWR   = 8'h08;
    localparam logic [7:0] A_STS   = 8'h0c;
    localparam logic [7:0] A_IREQ  = 8'h10;
    localparam logic [7:0] A_IDLE  = 8'h14;
    localparam logic [7:0] A_CDN   = 8'h34;
    localparam logic [7:0] A_CUP   = 8'h38;
    localparam logic [7:0] A_GDN   = 8'h3c;
    localparam logic [7:0] A_GUP   = 8'h40;

    typedef enum logic [1:0] {GRP_FIXED, GRP_CORE, GRP_GPU} grp_e;
    typedef enum logic [1:0] {PD_ON, PD_FALL, PD_OFF, PD_RISE} pd_state_e;

    function automatic int pwr_pos(input int d);
        case (d)
            0: return 7;
            1: return 14;
            2: return 8;
            default: return 9;
        endcase
    endfunction

    function automatic int sts_pos(input int d);
        case (d)
            0: return 7;
            1: return 10;
            2: return 8;
            default: return 9;
        endcase
    endfunction

    function automatic int req_pos(input int d);
        case (d)
            0: return 4;
            1: return 9;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic grp_e dom_grp(input int d);
        return (d == 3) ? GRP_GPU : GRP_FIXED;
    endfunction

endpackage

// File: rtl/pdc_tcnt.sv
module pdc_tcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q > CNT_W'(1))
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // a length of 0 or 1 both finish after one cycle
    assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/pdc_domain.sv
module pdc_domain
    import pdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_off,
    input  logic [CNT_W-1:0] dn_len,
    input  logic [CNT_W-1:0] up_len,
    output logic             pwr_en,
    output logic             st_off
);
    pd_state_e        state_q, state_d;
    logic             cnt_load, cnt_done;
    logic [CNT_W-1:0] cnt_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_ON:   if (req_off)  state_d = PD_FALL;
            PD_FALL: if (cnt_done) state_d = PD_OFF;
            PD_OFF:  if (!req_off) state_d = PD_RISE;
            PD_RISE: if (cnt_done) state_d = PD_ON;
        endcase
    end

    // length captured only when leaving a stable state
    assign cnt_load = ((state_q == PD_ON) && req_off) || ((state_q == PD_OFF) && !req_off);
    assign cnt_val  = req_off ? dn_len : up_len;

    pdc_tcnt #(.CNT_W(CNT_W)) u_tcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    always_comb begin
        pwr_en = (state_q == PD_ON)  || (state_q == PD_RISE);
        st_off = (state_q == PD_OFF) || (state_q == PD_RISE);
    end
endmodule

// File: rtl/pdc_top.sv
module pdc_top
    import pdc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DEF_LEN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NDOM-1:0]   pd_pwr_en,
    output logic [NDOM-1:0]   pd_idle_req,
    input  logic [NDOM-1:0]   pd_idle_ack,
    input  logic [NDOM-1:0]   pd_idle_st
);
    localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(DEF_LEN);

    logic [NDOM-1:0]  preq_q, ireq_q, st_off;
    logic [CNT_W-1:0] core_dn_q, core_up_q, gpu_dn_q, gpu_up_q;
    logic [DATA_W-1:0] rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preq_q    <= '0;
            ireq_q    <= '0;
            core_dn_q <= LEN_RST;
            core_up_q <= LEN_RST;
            gpu_dn_q  <= LEN_RST;
            gpu_up_q  <= LEN_RST;
        end else if (bus_wr) begin
            case (8'(bus_addr))
                A_PWR:  for (int d = 0; d < NDOM; d++) preq_q[d] <= bus_wdata[pwr_pos(d)];
                A_IREQ: for (int d = 0; d < NDOM; d++) ireq_q[d] <= bus_wdata[req_pos(d)];
                A_CDN:  core_dn_q <= bus_wdata[CNT_W-1:0];
                A_CUP:  core_up_q <= bus_wdata[CNT_W-1:0];
                A_GDN:  gpu_dn_q  <= bus_wdata[CNT_W-1:0];
                A_GUP:  gpu_up_q  <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        case (8'(bus_addr))
            A_PWR:  for (int d = 0; d < NDOM; d++) rd_val[pwr_pos(d)] = preq_q[d];
            A_STS:  for (int d = 0; d < NDOM; d++) rd_val[sts_pos(d)] = st_off[d];
            A_IREQ: for (int d = 0; d < NDOM; d++) rd_val[req_pos(d)] = ireq_q[d];
            A_IDLE: for (int d = 0; d < NDOM; d++) begin
                rd_val[req_pos(d)]             = pd_idle_st[d];
                rd_val[req_pos(d) + ACK_SHIFT] = pd_idle_ack[d];
            end
            A_CDN:  rd_val[CNT_W-1:0] = core_dn_q;
            A_CUP:  rd_val[CNT_W-1:0] = core_up_q;
            A_GDN:  rd_val[CNT_W-1:0] = gpu_dn_q;
            A_GUP:  rd_val[CNT_W-1:0] = gpu_up_q;
            default: ;
        endcase
    end

    assign bus_rdata   = bus_rd ? rd_val : '0;
    assign pd_idle_req = ireq_q;

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        logic [CNT_W-1:0] dn_len, up_len;
        if (dom_grp(g) == GRP_GPU) begin : g_gpu
            assign dn_len = gpu_dn_q;
            assign up_len = gpu_up_q;
        end else if (dom_grp(g) == GRP_CORE) begin : g_core
            assign dn_len = core_dn_q;
            assign up_len = core_up_q;
        end else begin : g_fixed
            assign dn_len = LEN_RST;
            assign up_len = LEN_RST;
        end

        pdc_domain #(.CNT_W(CNT_W)) u_dom (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_off (preq_q[g]),
            .dn_len  (dn_len),
            .up_len  (up_len),
            .pwr_en  (pd_pwr_en[g]),
            .st_off  (st_off[g])
        );
    end
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk
    import pdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NDOM-1:0]   preq,
    input logic [NDOM-1:0]   pwr_en,
    input logic [NDOM-1:0]   st_off,
    input logic [NDOM-1:0]   idle_req
);
    function automatic logic [DATA_W-1:0] pwr_mask();
        logic [DATA_W-1:0] m = '0;
        for (int d = 0; d < NDOM; d++) m[pwr_pos(d)] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] PWR_MASK = pwr_mask();

    for (genvar g = 0; g < NDOM; g++) begin : g_ast
        AST_CUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwr_en[g]) |-> $past(preq[g])); // R3
        AST_OFF_AFTER_CUT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_off[g]) |-> !pwr_en[g]); // R3
        AST_RESTORE_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_en[g]) |-> !$past(preq[g])); // R4
        AST_ON_WITH_POWER: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_off[g]) |-> pwr_en[g]); // R4
    end

    AST_IREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && (8'(bus_addr) == A_IREQ)) |-> $stable(idle_req)); // R5
    AST_PWR_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (8'(bus_addr) == A_PWR)) |-> ((bus_rdata & ~PWR_MASK) == '0)); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R9
endmodule

bind pdc_top pdc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .preq      (preq_q),
    .pwr_en    (pd_pwr_en),
    .st_off    (st_off),
    .idle_req  (pd_idle_req)
);

// File: tb/test_pdc_top.sv
`timescale 1ns/1ps
module test_pdc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pd_pwr_en, pd_idle_req, pd_idle_ack, pd_idle_st;
    logic [3:0]  d1, d2, d3;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int bp_pwr[4] = '{7, 14, 8, 9};
    int bp_sts[4] = '{7, 10, 8, 9};
    int bp_req[4] = '{4, 9, 3, 2};
    logic [31:0] pwr_sh = '0;
    logic [31:0] ireq_sh = '0;

    always #5 clk = ~clk;

    pdc_top i_pdc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pd_pwr_en(pd_pwr_en), .pd_idle_req(pd_idle_req),
        .pd_idle_ack(pd_idle_ack), .pd_idle_st(pd_idle_st)
    );

    // bus interface unit model: ack 2 cycles after request, idle 1 after ack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1 <= '0; d2 <= '0; d3 <= '0;
        end else begin
            d1 <= pd_idle_req; d2 <= d1; d3 <= d2;
        end
    end
    assign pd_idle_ack = d2;
    assign pd_idle_st  = d3;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pwr_cycle(input int d, input int n_dn, input int n_up);
        int nd = (n_dn < 1) ? 1 : n_dn;
        int nu = (n_up < 1) ? 1 : n_up;
        logic [31:0] ackb = 32'h1 << (bp_req[d] + 16);
        logic [31:0] idlb = 32'h1 << bp_req[d];
        logic [3:0]  others = 4'hF & ~(4'h1 << d);
        // idle handshake before power removal
        ireq_sh |= 32'h1 << bp_req[d];
        wr(8'h10, ireq_sh);
        chk("R5 idle req out", {28'h0, pd_idle_req}, 32'h1 << d);
        rd_chk("R6 ack low e0", 8'h14, 32'h0);
        step(1); rd_chk("R6 ack low e1", 8'h14, 32'h0);
        step(1); rd_chk("R6 ack set", 8'h14, ackb);
        step(1); rd_chk("R6 ack+idle set", 8'h14, ackb | idlb);
        // power down
        pwr_sh |= 32'h1 << bp_pwr[d];
        wr(8'h08, pwr_sh);
        rd_chk("R2 pwr readback", 8'h08, pwr_sh);
        chk("R3 enable before edge", {28'h0, pd_pwr_en}, 32'hF);
        step(1); chk("R3 enable cut", {28'h0, pd_pwr_en}, {28'h0, others});
        step(nd - 1); rd_chk("R3 status still on", 8'h0c, 32'h0);
        step(1); rd_chk("R3 status off", 8'h0c, 32'h1 << bp_sts[d]);
        // power up
        pwr_sh &= ~(32'h1 << bp_pwr[d]);
        wr(8'h08, pwr_sh);
        chk("R4 enable before edge", {28'h0, pd_pwr_en}, {28'h0, others});
        step(1); chk("R4 enable restored", {28'h0, pd_pwr_en}, 32'hF);
        step(nu - 1); rd_chk("R4 status still off", 8'h0c, 32'h1 << bp_sts[d]);
        step(1); rd_chk("R4 status on", 8'h0c, 32'h0);
        // release idle
        ireq_sh &= ~(32'h1 << bp_req[d]);
        wr(8'h10, ireq_sh);
        chk("R5 idle req released", {28'h0, pd_idle_req}, 32'h0);
        rd_chk("R6 both held e0", 8'h14, ackb | idlb);
        step(1); rd_chk("R6 both held e1", 8'h14, ackb | idlb);
        step(1); rd_chk("R6 ack clear", 8'h14, idlb);
        step(1); rd_chk("R6 idle clear", 8'h14, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 enables", {28'h0, pd_pwr_en}, 32'hF);
        chk("R1 idle req", {28'h0, pd_idle_req}, 32'h0);
        rd_chk("R1 pwr reg", 8'h08, 32'h0);
        rd_chk("R1 status", 8'h0c, 32'h0);
        rd_chk("R1 ireq reg", 8'h10, 32'h0);
        rd_chk("R1 core dn", 8'h34, 32'd24);
        rd_chk("R1 core up", 8'h38, 32'd24);
        rd_chk("R1 gpu dn", 8'h3c, 32'd24);
        rd_chk("R1 gpu up", 8'h40, 32'd24);
        // R7 length registers
        wr(8'h34, 32'd10); wr(8'h38, 32'd11); wr(8'h3c, 32'd5); wr(8'h40, 32'd7);
        rd_chk("R7 core dn", 8'h34, 32'd10);
        rd_chk("R7 core up", 8'h38, 32'd11);
        rd_chk("R7 gpu dn", 8'h3c, 32'd5);
        rd_chk("R7 gpu up", 8'h40, 32'd7);
        // full sequence on every island; islands 0..2 stay at 24 (R7)
        for (int d = 0; d < 4; d++) begin
            if (d == 3) pwr_cycle(d, 5, 7);
            else        pwr_cycle(d, 24, 24);
        end
        // R8 request retracted during fall of island 2
        pwr_sh = 32'h1 << 8;
        wr(8'h08, pwr_sh);
        step(4);
        pwr_sh = 32'h0;
        wr(8'h08, pwr_sh);
        rd_chk("R8 request reg updated", 8'h08, 32'h0);
        step(19);
        rd_chk("R8 still falling", 8'h0c, 32'h0);
        chk("R8 enable held low", {28'h0, pd_pwr_en}, 32'hB);
        step(1);
        rd_chk("R8 fall completes", 8'h0c, 32'h1 << 8);
        chk("R8 enable low in off", {28'h0, pd_pwr_en}, 32'hB);
        step(1);
        chk("R8 pending acted", {28'h0, pd_pwr_en}, 32'hF);
        step(23);
        rd_chk("R8 rise running", 8'h0c, 32'h1 << 8);
        step(1);
        rd_chk("R8 rise done", 8'h0c, 32'h0);
        // R10 zero length acts as one
        wr(8'h3c, 32'd0); wr(8'h40, 32'd1);
        pwr_cycle(3, 0, 1);
        // R9 unassigned bits and read-only registers
        wr(8'h08, 32'hFFFF_FFFF & ~((32'h1 << 7) | (32'h1 << 14) | (32'h1 << 8) | (32'h1 << 9)));
        rd_chk("R9 pwr spare bits", 8'h08, 32'h0);
        step(2);
        chk("R9 enables untouched", {28'h0, pd_pwr_en}, 32'hF);
        wr(8'h10, 32'hFFFF_FFFF & ~((32'h1 << 4) | (32'h1 << 9) | (32'h1 << 3) | (32'h1 << 2)));
        chk("R9 ireq spare bits", {28'h0, pd_idle_req}, 32'h0);
        rd_chk("R9 ireq reg", 8'h10, 32'h0);
        wr(8'h0c, 32'hFFFF_FFFF);
        step(2);
        rd_chk("R9 status read-only", 8'h0c, 32'h0);
        chk("R9 status write no cut", {28'h0, pd_pwr_en}, 32'hF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R9 idle reg read-only", 8'h14, 32'h0);
        rd_chk("R9 unmapped", 8'h20, 32'h0);
        bus_addr = 8'h3c; #1;
        chk("R9 no read strobe", bus_rdata, 32'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule